// File: doc/BRIEF.md
# VLAN Attribute Table

This block keeps one attribute record per VLAN and answers lookups against it. Each record holds a destination port mask, a filtering database number, a drop flag and a priority policy. A lookup carries a frame's VLAN number and the priority the ingress endpoint gave the frame. It returns the record's port mask, filtering database number and drop decision, together with the final frame priority after the record's priority policy has been applied.

Software never writes the table directly. It fills a mask staging register and then writes an attribute staging register. That second write carries the VLAN number, the attribute fields and a commit bit. When the commit bit is set, both staged values are copied into the record for the staged VLAN number on the next clock. This means one bus write both selects the record and updates it.

Top module: `vlan_attr_table`

## Requirements
- R1: The table has one record per 12-bit VLAN number (4096 records). After reset, every record is all zeros: port mask 0, database number 0, no drop, and neither priority flag set.
- R2: The attribute staging register sits at byte offset 0xC and has these fields: VLAN number in bits 11:0, database number in 19:12, drop flag at bit 20, has-priority flag at bit 21, override flag at bit 22, priority in 25:23 and commit at bit 26. Reading it back returns the stored fields, with bits 31:26 always 0.
- R3: The mask staging register sits at byte offset 0x10. It holds a 32-bit destination port mask and reads back as written.
- R4: Writing the attribute register with bit 26 set copies both staging registers into the record named by the written VLAN number. Writing it with bit 26 clear leaves the table unchanged.
- R5: Every lookup request produces exactly one result. The result is marked by a one-cycle `rs_valid` pulse exactly two clock cycles after the request. Requests may be issued on back-to-back cycles.
- R6: A lookup whose record has the drop flag set returns `rs_drop` = 1. In every other case `rs_drop` is 0.
- R7: When the record's override flag is set, the result priority is the record's priority, whatever the frame's own priority is.
- R8: When the record's has-priority flag is set and its override flag is clear, the record's priority is used only for a frame that arrived without a priority. A frame that carries a priority keeps its own.
- R9: When neither flag is set, the frame's priority passes through unchanged.
- R10: Consider a lookup issued in the cycle right after a committing bus write, which is the cycle the commit is applied. That lookup returns the record as it was before the commit. A lookup issued one cycle later returns the new record.
- R11: Reset clears both staging registers. Bus read data appears one cycle after `bus_rd`, and offsets other than 0xC and 0x10 read as 0.
- R12: While `rs_valid` is low, `rs_mask`, `rs_fid`, `rs_drop` and `rs_prio` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, one cycle after `bus_rd` |
| lk_req | input | 1 | Lookup request |
| lk_vid | input | 12 | VLAN number of the frame |
| lk_prio | input | 3 | Priority assigned to the frame by the endpoint |
| lk_prio_ok | input | 1 | Frame carries its own priority |
| rs_valid | output | 1 | Result pulse |
| rs_mask | output | 32 | Destination port mask |
| rs_fid | output | 8 | Filtering database number |
| rs_drop | output | 1 | Drop decision |
| rs_prio | output | 3 | Resolved frame priority |

## Verification
Lookups are run against records holding every combination of the two priority flags, each paired with frames that do and do not carry a priority. This separates override from fill-in from pass-through. Lookups to untouched records, including VLAN numbers 0 and 4095, show the zeroed reset contents. A staged write without the commit bit shows that staging alone changes nothing. A lookup placed in the same cycle as a commit, followed by one a cycle later, pins down the old-versus-new ordering. Back-to-back requests checked against per-request due cycles confirm the fixed two-cycle latency.

// File: rtl/vat_pkg.sv
package vat_pkg;

   // register decode result
   typedef enum logic [1:0] {
      VAT_SEL_NONE,
      VAT_SEL_ATTR,
      VAT_SEL_MASK
   } vat_sel_e;

   // true when the record's own priority replaces the frame priority
   function automatic logic vat_take_entry_prio(input logic ovr,
                                                input logic ent_has,
                                                input logic frm_has);
      return ovr | (ent_has & ~frm_has);
   endfunction

endpackage

// File: rtl/vat_stage_regs.sv
module vat_stage_regs
   import vat_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int VID_W    = 12,
   parameter int FID_W    = 8,
   parameter int PRIO_W   = 3,
   parameter int MASK_W   = 32,
   parameter int ATTR_OFS = 12,
   parameter int MASK_OFS = 16,
   parameter bit RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [VID_W-1:0]  stg_vid,
   output logic [FID_W-1:0]  stg_fid,
   output logic              stg_drop,
   output logic              stg_has,
   output logic              stg_ovr,
   output logic [PRIO_W-1:0] stg_prio,
   output logic [MASK_W-1:0] stg_mask,
   output logic              commit
);

   localparam int FID_LSB  = VID_W;
   localparam int DROP_BIT = FID_LSB + FID_W;
   localparam int HAS_BIT  = DROP_BIT + 1;
   localparam int OVR_BIT  = HAS_BIT + 1;
   localparam int PRIO_LSB = OVR_BIT + 1;
   localparam int UPD_BIT  = PRIO_LSB + PRIO_W;
   localparam int ATTR_W   = UPD_BIT;

   // elaboration-time parameter checks
   if (UPD_BIT >= DATA_W) begin : g_bad_layout
      $error("attribute fields do not fit the data width");
   end
   if (MASK_W > DATA_W) begin : g_bad_mask
      $error("port mask wider than the data width");
   end
   if (ATTR_OFS == MASK_OFS) begin : g_bad_ofs
      $error("staging registers share one offset");
   end
   if (MASK_OFS >= (1 << ADDR_W) || ATTR_OFS >= (1 << ADDR_W)) begin : g_bad_addr
      $error("offsets exceed the address width");
   end

   logic [ATTR_W-1:0] attr_q;
   logic [MASK_W-1:0] mask_q;
   logic              commit_q;
   vat_sel_e          sel;
   logic [DATA_W-1:0] rd_val;
   logic              unused_wdata;

   assign unused_wdata = ^bus_wdata[DATA_W-1:UPD_BIT+1];

   always_comb begin
      sel = VAT_SEL_NONE;
      if (bus_addr == ADDR_W'(ATTR_OFS))
         sel = VAT_SEL_ATTR;
      else if (bus_addr == ADDR_W'(MASK_OFS))
         sel = VAT_SEL_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         attr_q   <= '0;
         mask_q   <= '0;
         commit_q <= 1'b0;
      end else begin
         commit_q <= 1'b0;
         if (bus_wr && sel == VAT_SEL_ATTR) begin
            attr_q   <= bus_wdata[ATTR_W-1:0];
            commit_q <= bus_wdata[UPD_BIT];
         end
         if (bus_wr && sel == VAT_SEL_MASK)
            mask_q <= bus_wdata[MASK_W-1:0];
      end
   end

   always_comb begin
      rd_val = '0;
      case (sel)
         VAT_SEL_ATTR: rd_val[ATTR_W-1:0] = attr_q;
         VAT_SEL_MASK: rd_val[MASK_W-1:0] = mask_q;
         default: ;
      endcase
   end

   if (RD_REG) begin : g_rd_reg
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            rdata_q <= '0;
         else if (bus_rd)
            rdata_q <= rd_val;
      end
      assign bus_rdata = rdata_q;

      // R2
      attr_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rd && sel == VAT_SEL_ATTR |=> bus_rdata[DATA_W-1:UPD_BIT] == '0);
      // R11
      unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bus_rd && sel == VAT_SEL_NONE |=> bus_rdata == '0);
   end else begin : g_rd_comb
      logic unused_rd;
      assign unused_rd = bus_rd;
      assign bus_rdata = rd_val;
   end

   assign stg_vid  = attr_q[VID_W-1:0];
   assign stg_fid  = attr_q[FID_LSB +: FID_W];
   assign stg_drop = attr_q[DROP_BIT];
   assign stg_has  = attr_q[HAS_BIT];
   assign stg_ovr  = attr_q[OVR_BIT];
   assign stg_prio = attr_q[PRIO_LSB +: PRIO_W];
   assign stg_mask = mask_q;
   assign commit   = commit_q;

endmodule

// File: rtl/vat_table_mem.sv
module vat_table_mem #(
   parameter int VID_W = 12,
   parameter int ENT_W = 46
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [VID_W-1:0] wr_addr,
   input  logic [ENT_W-1:0] wr_data,
   input  logic             rd_en,
   input  logic [VID_W-1:0] rd_addr,
   output logic [ENT_W-1:0] rd_data
);

   localparam int DEPTH = 1 << VID_W;

   if (VID_W < 1 || VID_W > 12) begin : g_bad_depth
      $error("table index width out of range");
   end

   logic [ENT_W-1:0] mem [DEPTH];
   logic [DEPTH-1:0] filled;
   logic [ENT_W-1:0] rd_q;
   logic             hit_q;

   // storage: no reset, read-before-write on a shared edge
   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_addr] <= wr_data;
      if (rd_en)
         rd_q <= mem[rd_addr];
   end

   // written-since-reset bitmap gives the all-zero reset contents
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filled <= '0;
         hit_q  <= 1'b0;
      end else begin
         if (wr_en)
            filled[wr_addr] <= 1'b1;
         if (rd_en)
            hit_q <= filled[rd_addr];
      end
   end

   assign rd_data = hit_q ? rd_q : '0;

   // R4
   commit_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> filled[$past(wr_addr)]);
   // R1
   blank_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !filled[rd_addr] && !(wr_en && wr_addr == rd_addr) |=> rd_data == '0);

endmodule

// File: rtl/vat_prio_resolve.sv
module vat_prio_resolve
   import vat_pkg::*;
#(
   parameter int FID_W  = 8,
   parameter int PRIO_W = 3,
   parameter int MASK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_vld,
   input  logic [MASK_W-1:0] ent_mask,
   input  logic [FID_W-1:0]  ent_fid,
   input  logic              ent_drop,
   input  logic              ent_has,
   input  logic              ent_ovr,
   input  logic [PRIO_W-1:0] ent_prio,
   input  logic [PRIO_W-1:0] frm_prio,
   input  logic              frm_has,
   output logic              out_vld,
   output logic [MASK_W-1:0] out_mask,
   output logic [FID_W-1:0]  out_fid,
   output logic              out_drop,
   output logic [PRIO_W-1:0] out_prio
);

   logic [PRIO_W-1:0] pick;

   always_comb begin
      pick = frm_prio;
      if (vat_take_entry_prio(ent_ovr, ent_has, frm_has))
         pick = ent_prio;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !in_vld) begin
         out_vld  <= 1'b0;
         out_mask <= '0;
         out_fid  <= '0;
         out_drop <= 1'b0;
         out_prio <= '0;
      end else begin
         out_vld  <= 1'b1;
         out_mask <= ent_mask;
         out_fid  <= ent_fid;
         out_drop <= ent_drop;
         out_prio <= pick;
      end
   end

   // R7
   override_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && ent_ovr |=> out_prio == $past(ent_prio));
   // R6
   drop_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld && ent_drop |=> out_drop);
   // R12
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> (out_mask == '0 && out_fid == '0 && !out_drop && out_prio == '0));

endmodule

// File: rtl/vlan_attr_table.sv
module vlan_attr_table #(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int VID_W    = 12,
   parameter int FID_W    = 8,
   parameter int PRIO_W   = 3,
   parameter int MASK_W   = 32,
   parameter int ATTR_OFS = 12,
   parameter int MASK_OFS = 16,
   parameter bit RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              lk_req,
   input  logic [VID_W-1:0]  lk_vid,
   input  logic [PRIO_W-1:0] lk_prio,
   input  logic              lk_prio_ok,
   output logic              rs_valid,
   output logic [MASK_W-1:0] rs_mask,
   output logic [FID_W-1:0]  rs_fid,
   output logic              rs_drop,
   output logic [PRIO_W-1:0] rs_prio
);

   // record layout: {mask, fid, drop, has, ovr, prio}
   localparam int PRIO_LSB = 0;
   localparam int OVR_BIT  = PRIO_LSB + PRIO_W;
   localparam int HAS_BIT  = OVR_BIT + 1;
   localparam int DROP_BIT = HAS_BIT + 1;
   localparam int FID_LSB  = DROP_BIT + 1;
   localparam int MASK_LSB = FID_LSB + FID_W;
   localparam int ENT_W    = MASK_LSB + MASK_W;

   logic [VID_W-1:0]  stg_vid;
   logic [FID_W-1:0]  stg_fid;
   logic              stg_drop;
   logic              stg_has;
   logic              stg_ovr;
   logic [PRIO_W-1:0] stg_prio;
   logic [MASK_W-1:0] stg_mask;
   logic              commit;
   logic [ENT_W-1:0]  wr_ent;
   logic [ENT_W-1:0]  rd_ent;

   logic              s1_vld;
   logic [PRIO_W-1:0] s1_prio;
   logic              s1_prio_ok;

   vat_stage_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .VID_W(VID_W), .FID_W(FID_W),
      .PRIO_W(PRIO_W), .MASK_W(MASK_W), .ATTR_OFS(ATTR_OFS),
      .MASK_OFS(MASK_OFS), .RD_REG(RD_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .stg_vid(stg_vid), .stg_fid(stg_fid), .stg_drop(stg_drop),
      .stg_has(stg_has), .stg_ovr(stg_ovr), .stg_prio(stg_prio),
      .stg_mask(stg_mask), .commit(commit)
   );

   assign wr_ent = {stg_mask, stg_fid, stg_drop, stg_has, stg_ovr, stg_prio};

   vat_table_mem #(
      .VID_W(VID_W), .ENT_W(ENT_W)
   ) u_mem (
      .clk(clk), .rst_n(rst_n),
      .wr_en(commit), .wr_addr(stg_vid), .wr_data(wr_ent),
      .rd_en(lk_req), .rd_addr(lk_vid), .rd_data(rd_ent)
   );

   // stage 1: frame side travels alongside the table read
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_vld     <= 1'b0;
         s1_prio    <= '0;
         s1_prio_ok <= 1'b0;
      end else begin
         s1_vld     <= lk_req;
         s1_prio    <= lk_prio;
         s1_prio_ok <= lk_prio_ok;
      end
   end

   // stage 2: policy and output register
   vat_prio_resolve #(
      .FID_W(FID_W), .PRIO_W(PRIO_W), .MASK_W(MASK_W)
   ) u_res (
      .clk(clk), .rst_n(rst_n), .in_vld(s1_vld),
      .ent_mask(rd_ent[MASK_LSB +: MASK_W]),
      .ent_fid(rd_ent[FID_LSB +: FID_W]),
      .ent_drop(rd_ent[DROP_BIT]),
      .ent_has(rd_ent[HAS_BIT]),
      .ent_ovr(rd_ent[OVR_BIT]),
      .ent_prio(rd_ent[PRIO_LSB +: PRIO_W]),
      .frm_prio(s1_prio), .frm_has(s1_prio_ok),
      .out_vld(rs_valid), .out_mask(rs_mask), .out_fid(rs_fid),
      .out_drop(rs_drop), .out_prio(rs_prio)
   );

   // R5
   lookup_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |-> ##2 rs_valid);
   // R5
   no_orphan_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid |-> $past(lk_req, 2));

endmodule

// File: tb/sim_vlan_attr_table.sv
module sim_vlan_attr_table;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        lk_req = 1'b0;
   logic [11:0] lk_vid = '0;
   logic [2:0]  lk_prio = '0;
   logic        lk_prio_ok = 1'b0;
   logic        rs_valid;
   logic [31:0] rs_mask;
   logic [7:0]  rs_fid;
   logic        rs_drop;
   logic [2:0]  rs_prio;

   always #10 clk = ~clk;

   vlan_attr_table u0 (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .lk_req(lk_req), .lk_vid(lk_vid), .lk_prio(lk_prio),
      .lk_prio_ok(lk_prio_ok),
      .rs_valid(rs_valid), .rs_mask(rs_mask), .rs_fid(rs_fid),
      .rs_drop(rs_drop), .rs_prio(rs_prio)
   );

   int n_run = 0, n_fail = 0, cyc = 0;
   bit done = 1'b0;

   logic [45:0] mdl [int];   // {mask, fid, drop, has, ovr, prio}
   logic [43:0] exp_q [$];   // {mask, fid, drop, prio}
   string       tag_q [$];
   int          due_q [$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] attr_word(int vid, int fid, bit drop, bit has,
                                             bit ovr, int prio, bit upd);
      return {5'b0, upd, 3'(prio), ovr, has, drop, 8'(fid), 12'(vid)};
   endfunction

   function automatic void set_model(int vid, int fid, bit drop, bit has,
                                     bit ovr, int prio, logic [31:0] mask);
      mdl[vid] = {mask, 8'(fid), drop, has, ovr, 3'(prio)};
   endfunction

   function automatic logic [43:0] predict(int vid, logic [2:0] fp, logic fok);
      logic [45:0] e;
      logic [2:0]  p;
      e = mdl.exists(vid) ? mdl[vid] : '0;
      p = (e[3] || (e[4] && !fok)) ? e[2:0] : fp;
      return {e[45:14], e[13:6], e[5], p};
   endfunction

   task automatic bus_write(int addr, logic [31:0] data);
      bus_wr = 1'b1; bus_addr = 5'(addr); bus_wdata = data;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read_chk(int addr, logic [31:0] exp, string req);
      bus_rd = 1'b1; bus_addr = 5'(addr);
      @(negedge clk);
      bus_rd = 1'b0;
      chk(req, 64'(bus_rdata), 64'(exp));
   endtask

   task automatic look(int vid, int fp, bit fok, string req);
      lk_req = 1'b1; lk_vid = 12'(vid); lk_prio = 3'(fp); lk_prio_ok = fok;
      exp_q.push_back(predict(vid, 3'(fp), fok));
      tag_q.push_back(req);
      due_q.push_back(cyc + 2);
      @(negedge clk);
      lk_req = 1'b0;
   endtask

   task automatic commit_entry(int vid, int fid, bit drop, bit has, bit ovr,
                               int prio, logic [31:0] mask);
      bus_write(16, mask);
      bus_write(12, attr_word(vid, fid, drop, has, ovr, prio, 1'b1));
      set_model(vid, fid, drop, has, ovr, prio, mask);
      @(negedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (rs_valid) begin
            if (exp_q.size() == 0) begin
               n_run++; n_fail++;
               $display("FAIL R5: actual=result expected=none");
            end else begin
               logic [43:0] e;
               string t;
               int d;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               d = due_q.pop_front();
               chk("R5 latency", 64'(cyc), 64'(d));
               chk(t, 64'({rs_mask, rs_fid, rs_drop, rs_prio}), 64'(e));
            end
         end else begin
            chk("R12", 64'({rs_mask, rs_fid, rs_drop, rs_prio}), 64'd0);
         end
      end
   end

   task automatic finish_run();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R5: actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: staging cleared, unmapped reads zero
      bus_read_chk(12, 32'h0, "R11 attr reset");
      bus_read_chk(16, 32'h0, "R11 mask reset");
      bus_read_chk(0, 32'h0, "R11 unmapped");

      // R1 / R9: blank records at both ends of the index range
      look(0, 5, 1'b1, "R1 vid0");
      look(4095, 6, 1'b0, "R1 vid4095");
      look(77, 2, 1'b1, "R9 blank");
      idle(3);

      // R2 / R3 / R4 / R8
      commit_entry(5, 8'h3C, 1'b0, 1'b1, 1'b0, 2, 32'hA5A5_0F0F);
      bus_read_chk(12, attr_word(5, 8'h3C, 0, 1, 0, 2, 0), "R2 readback");
      bus_read_chk(16, 32'hA5A5_0F0F, "R3 readback");
      look(5, 6, 1'b1, "R8 frame keeps prio");
      look(5, 6, 1'b0, "R8 entry fills prio");
      idle(3);

      // R6 / R7: drop and override at the top index
      commit_entry(4095, 8'hFF, 1'b1, 1'b0, 1'b1, 7, 32'hFFFF_FFFF);
      look(4095, 1, 1'b1, "R7 override");
      look(4095, 0, 1'b0, "R6 drop");
      // override together with has-priority
      commit_entry(0, 8'h01, 1'b0, 1'b1, 1'b1, 4, 32'h0000_0001);
      look(0, 3, 1'b1, "R7 override with has");
      // R9: no flags
      commit_entry(300, 8'h11, 1'b0, 1'b0, 1'b0, 5, 32'h1234_5678);
      look(300, 1, 1'b1, "R9 passthrough");
      look(300, 3, 1'b0, "R9 passthrough no prio");
      idle(3);

      // R4: staging without commit bit leaves the table alone
      bus_write(16, 32'hDEAD_BEEF);
      bus_write(12, attr_word(9, 8'h22, 1, 1, 1, 3, 0));
      idle(1);
      look(9, 4, 1'b1, "R4 no commit");
      bus_read_chk(12, attr_word(9, 8'h22, 1, 1, 1, 3, 0), "R2 staged only");
      idle(3);

      // R10: lookup in the commit cycle sees the old record
      bus_write(16, 32'h0000_F00D);
      bus_write(12, attr_word(5, 8'h99, 1, 0, 1, 1, 1));
      look(5, 6, 1'b0, "R10 old record");
      set_model(5, 8'h99, 1'b1, 1'b0, 1'b1, 1, 32'h0000_F00D);
      look(5, 6, 1'b0, "R10 new record");

      // R5: back-to-back mixed lookups
      for (int i = 0; i < 8; i++)
         look((i % 2) ? 300 : 4095, i, i[0], "R5 back-to-back");
      idle(4);

      chk("R5 all results seen", 64'(exp_q.size()), 64'd0);
      finish_run();
   end

endmodule